// File: doc/BRIEF.md
# Power island sequencing controller

This controller governs the supply of a single switchable logic island that is split into three sub-domains. Each sub-domain has its own power enable. When the island's power request goes from low to high while every enable is off, the controller switches the enables on one at a time, with a fixed spacing between them. This limits the inrush current on the shared rail. Once the ramp completes, the controller issues a one-cycle restore strobe so the island's retention registers reload their saved state. It then reports the island as fully on.

Power is removed only while the island reports that it is idle. In the full-on state, a low request together with a high idle flag commits a power-down. The controller first issues a one-cycle save strobe. It then holds the enables through a four-cycle window and drops them all together at the end of that window. If idle falls at any point inside the window, the power-down is cancelled and no enable is touched.

If the request falls while the ramp is still running, the ramp is abandoned. The enables that are already on are unwound, highest first, one per cycle, and no restore strobe is sent. If a new request edge arrives during a committed power-down, it is remembered and acted on once the island is dark.

Top module: `pwr_island_seq`

## Requirements
- R1: While reset is asserted and directly after it, all three enables, the save strobe, the restore strobe and the full-on flag are low.
- R2: A rising edge of the request, sampled at a clock edge while all enables are off, sets enable bit 0 (value 3'b001) in the first cycle after that edge.
- R3: During the ramp, the enable vector is a thermometer code in which bit i belongs to sub-domain i. Bit 1 is set in cycle 9 and bit 2 in cycle 17, counted from the rise (3'b011, then 3'b111). At most one bit turns on per cycle.
- R4: The restore strobe is high for exactly one cycle, in cycle 18 after the rise, and the full-on flag rises in that same cycle.
- R5: A request sampled low during the ramp stops it. No further bit turns on, the bits already on turn off highest first, one per cycle starting in the next cycle, and no restore strobe is issued.
- R6: In the full-on state, a low request with idle high gives a save strobe in the next cycle, with all enables still on. All enables then go low together in the fourth cycle, provided idle stays high.
- R7: If idle is sampled low during the power-down window, the power-down is cancelled. No enable drops, and the full-on flag returns in the next cycle.
- R8: A request rise during a committed power-down does not stop it. Bit 0 turns on in the cycle after the enables reach 3'b000.
- R9: The full-on flag is high only when all three enables are on and neither a ramp nor a power-down window is running.
- R10: A request rise while the enables are unwinding after an abort is ignored. The enables reach 3'b000 and stay off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_req_i | input | 1 | Island power request (high means power wanted) |
| idle_i | input | 1 | Island idle flag; power-down proceeds only while high |
| pwr_en_o | output | 3 | Sub-domain power enables, bit i for sub-domain i |
| save_o | output | 1 | One-cycle strobe to save retention state |
| restore_o | output | 1 | One-cycle strobe to restore retention state |
| full_on_o | output | 1 | Island fully powered, with no sequence in progress |

## Verification
Every output is registered, so each result is due a fixed number of cycles after the edge that samples a stimulus. The timings are: bit 0 one cycle after the rise; bits 1 and 2 at cycles 9 and 17; restore and full-on at cycle 18; save one cycle after the power-down condition; enables low at cycle 4; the abort unwind one bit per cycle starting the cycle after the low request. The bench changes its inputs only on falling edges and reads the outputs on falling edges. A behavioural model, advanced on each rising edge, gives the expected value for every cycle. Targeted checks at exactly these cycle counts name the requirement they cover.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_RAMP,
    ST_ON,
    ST_DOWN,
    ST_UNWIND
  } seq_state_e;
endpackage

// File: rtl/pwr_rise_det.sv
module pwr_rise_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/pwr_step_timer.sv
module pwr_step_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= CNT_W'(1);
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end

  AST_TIMER_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i) |-> cnt_o != '1); // R3
endmodule

// File: rtl/pwr_island_seq.sv
module pwr_island_seq
  import pwr_seq_pkg::*;
#(
  parameter int N_DOM    = 3,
  parameter int STEP     = 8,
  parameter int DOWN_WIN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_req_i,
  input  logic             idle_i,
  output logic [N_DOM-1:0] pwr_en_o,
  output logic             save_o,
  output logic             restore_o,
  output logic             full_on_o
);
  localparam int RAMP_END = (N_DOM - 1) * STEP + 1;
  localparam int CNT_MAX  = (RAMP_END > DOWN_WIN) ? RAMP_END : DOWN_WIN;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);

  seq_state_e       state_q, state_d;
  logic [N_DOM-1:0] en_q, en_d, on_mask;
  logic             save_q, save_d, rest_q, rest_d, pend_q, pend_d;
  logic             rise, cnt_clr, cnt_inc;
  logic [CNT_W-1:0] cnt;

  pwr_rise_det u_rise (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (pwr_req_i),
    .rise_o(rise)
  );

  pwr_step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .inc_i (cnt_inc),
    .cnt_o (cnt)
  );

  // bit g switches on at the edge that moves the counter past g*STEP
  assign on_mask[0] = 1'b0;
  for (genvar g = 1; g < N_DOM; g++) begin : g_on
    assign on_mask[g] = (cnt == CNT_W'(g * STEP));
  end

  always_comb begin
    state_d = state_q;
    en_d    = en_q;
    save_d  = 1'b0;
    rest_d  = 1'b0;
    pend_d  = pend_q;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    unique case (state_q)
      ST_OFF: begin
        pend_d = 1'b0;
        if ((rise || pend_q) && pwr_req_i) begin
          state_d = ST_RAMP;
          en_d    = N_DOM'(1);
          cnt_clr = 1'b1;
        end
      end
      ST_RAMP: begin
        if (!pwr_req_i) begin
          en_d    = en_q >> 1;
          state_d = ((en_q >> 1) == '0) ? ST_OFF : ST_UNWIND;
        end else if (cnt == CNT_W'(RAMP_END)) begin
          state_d = ST_ON;
          rest_d  = 1'b1;
        end else begin
          cnt_inc = 1'b1;
          en_d    = en_q | on_mask;
        end
      end
      ST_ON: begin
        if (!pwr_req_i && idle_i) begin
          state_d = ST_DOWN;
          save_d  = 1'b1;
          cnt_clr = 1'b1;
          pend_d  = 1'b0;
        end
      end
      ST_DOWN: begin
        if (!idle_i) begin
          state_d = ST_ON;
          pend_d  = 1'b0;
        end else begin
          pend_d = pend_q | rise;
          if (cnt == CNT_W'(DOWN_WIN - 1)) begin
            en_d    = '0;
            state_d = ST_OFF;
          end else begin
            cnt_inc = 1'b1;
          end
        end
      end
      ST_UNWIND: begin
        en_d = en_q >> 1;
        if ((en_q >> 1) == '0) state_d = ST_OFF;
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      en_q    <= '0;
      save_q  <= 1'b0;
      rest_q  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      en_q    <= en_d;
      save_q  <= save_d;
      rest_q  <= rest_d;
      pend_q  <= pend_d;
    end
  end

  assign pwr_en_o  = en_q;
  assign save_o    = save_q;
  assign restore_o = rest_q;
  assign full_on_o = (state_q == ST_ON);

  AST_RESET_DARK: assert property (@(posedge clk_i)
    !rst_ni |=> (pwr_en_o == '0 || !rst_ni)); // R1
  AST_START_FROM_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pwr_en_o) == '0 && pwr_en_o != '0) |-> pwr_en_o == N_DOM'(1)); // R2
  AST_ONE_BIT_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(pwr_en_o & ~$past(pwr_en_o)) <= 1); // R3
  AST_THERMO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_en_o & N_DOM'(pwr_en_o + 1'b1)) == '0); // R3
  AST_RESTORE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_o |-> (full_on_o && !$past(restore_o))); // R4
  AST_ABORT_UNWIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_RAMP && !$past(pwr_req_i)) |-> (pwr_en_o == ($past(pwr_en_o) >> 1) && !restore_o)); // R5
  AST_SAVE_ALL_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_o |-> &pwr_en_o); // R6
  AST_DROP_ONLY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == ST_DOWN && pwr_en_o != $past(pwr_en_o)) |-> ($past(idle_i) && pwr_en_o == '0)); // R7
  AST_FULL_ON_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_on_o |-> &pwr_en_o); // R9
endmodule

// File: tb/sim_pwr_island_seq.sv
module sim_pwr_island_seq;
  logic       clk = 1'b0, rst_n = 1'b0, req = 1'b0, idle = 1'b0;
  logic [2:0] en;
  logic       save, rest, full;
  int         checks = 0, errors = 0, cyc = 0;
  string      tag = "R1";

  always #5 clk = ~clk;

  pwr_island_seq u0 (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .pwr_req_i(req),
    .idle_i   (idle),
    .pwr_en_o (en),
    .save_o   (save),
    .restore_o(rest),
    .full_on_o(full)
  );

  // behavioural model: mode 0 off, 1 ramp, 2 on, 3 down window, 4 unwind
  int m_mode = 0, m_lit = 0, m_age = 0;
  bit m_pend = 0, m_prev = 0, m_save = 0, m_rest = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_lit = 0; m_age = 0;
      m_pend = 0; m_prev = 0; m_save = 0; m_rest = 0;
    end else begin
      bit up;
      up = req && !m_prev;
      m_save = 0; m_rest = 0;
      case (m_mode)
        0: begin
          if ((up || m_pend) && req) begin m_mode = 1; m_age = 1; m_lit = 1; end
          m_pend = 0;
        end
        1: begin
          if (!req) begin m_lit--; m_mode = (m_lit == 0) ? 0 : 4; end
          else if (m_age == 17) begin m_mode = 2; m_rest = 1; end
          else begin
            m_age++;
            if (m_age == 9)  m_lit = 2;
            if (m_age == 17) m_lit = 3;
          end
        end
        2: if (!req && idle) begin m_mode = 3; m_age = 1; m_save = 1; m_pend = 0; end
        3: begin
          if (!idle) begin m_mode = 2; m_pend = 0; end
          else begin
            if (up) m_pend = 1;
            if (m_age == 3) begin m_lit = 0; m_mode = 0; end
            else m_age++;
          end
        end
        default: begin m_lit--; if (m_lit == 0) m_mode = 0; end
      endcase
      m_prev = req;
    end
  end

  task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk({tag, " model en"}, 32'(en), 32'((1 << m_lit) - 1));
      chk({tag, " model save"}, 32'(save), 32'(m_save));
      chk({tag, " model restore"}, 32'(rest), 32'(m_rest));
      chk({tag, " model full_on"}, 32'(full), 32'(m_mode == 2));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog R1 actual=%0d expected=<20000", cyc);
      finish_sim();
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    step(3);
    chk("R1 reset en", 32'(en), 0);
    chk("R1 reset strobes", 32'({save, rest, full}), 0);
    rst_n = 1'b1;
    step(1);
    chk("R1 after reset en", 32'(en), 0);

    tag = "R2"; req = 1'b1;
    step(1);  chk("R2 bit0 cycle1", 32'(en), 32'h1);
    tag = "R3";
    step(7);  chk("R3 cycle8 still bit0", 32'(en), 32'h1);
    step(1);  chk("R3 bit1 cycle9", 32'(en), 32'h3);
    chk("R9 full_on low in ramp", 32'(full), 0);
    step(7);  chk("R3 cycle16", 32'(en), 32'h3);
    step(1);  chk("R3 bit2 cycle17", 32'(en), 32'h7);
    chk("R4 no restore cycle17", 32'(rest), 0);
    tag = "R4";
    step(1);  chk("R4 restore cycle18", 32'(rest), 1);
    chk("R4 full_on cycle18", 32'(full), 1);
    step(1);  chk("R4 restore one cycle", 32'(rest), 0);
    step(2);

    tag = "R7"; idle = 1'b1; req = 1'b0;
    step(1);  chk("R6 save cycle1", 32'(save), 1);
    chk("R6 en on at save", 32'(en), 32'h7);
    chk("R9 full_on low in window", 32'(full), 0);
    idle = 1'b0;
    step(1);  chk("R7 cancel full_on", 32'(full), 1);
    step(4);  chk("R7 en kept", 32'(en), 32'h7);

    tag = "R6"; idle = 1'b1;
    step(1);  chk("R6 save", 32'(save), 1);
    step(2);  chk("R6 en cycle3", 32'(en), 32'h7);
    step(1);  chk("R6 en off cycle4", 32'(en), 32'h0);
    chk("R6 full_on off", 32'(full), 0);
    step(2);

    tag = "R5"; idle = 1'b0; req = 1'b1;
    step(10); chk("R5 pre-abort", 32'(en), 32'h3);
    req = 1'b0;
    step(1);  chk("R5 unwind bit1", 32'(en), 32'h1);
    tag = "R10"; req = 1'b1;
    step(1);  chk("R5 unwind bit0", 32'(en), 32'h0);
    step(20); chk("R10 rise ignored", 32'(en), 32'h0);
    chk("R5 no restore", 32'(rest), 0);
    req = 1'b0;
    step(2);

    tag = "R8"; req = 1'b1;
    step(19); chk("R8 full_on reached", 32'(full), 1);
    idle = 1'b1; req = 1'b0;
    step(1);  chk("R8 save", 32'(save), 1);
    req = 1'b1;
    step(3);  chk("R8 off despite request", 32'(en), 32'h0);
    step(1);  chk("R8 restart bit0", 32'(en), 32'h1);
    step(20); chk("R8 full_on again", 32'(full), 1);

    finish_sim();
  end
endmodule